// File: doc/BRIEF.md
# Network Controller Status Flag Register

This block holds the sticky event flags of a token-passing network controller and reports them to a host. The packet engine raises single-cycle pulses when something happens: a local packet finishes arriving, a watched source ID is heard, a token is retried, a damaged acknowledge is repaired, the hub watchdog expires, a packet carries a bad page offset, a core event occurs, or a free-buffer enquiry gets no answer. Each pulse latches a flag. The flag stays set until the host clears it.

The host reaches the block through a plain register port. A write strobe, an address and write data are captured on the rising clock edge. Read data follows the address combinationally. The host clears a status flag by writing 1 to its bit, sets which flags may drive the summary interrupt, programs the source ID to watch and the core-event mask, and issues software-reset and send commands.

The register map is:
- 0: status. Writing 1 to a bit clears that flag.
- 1: interrupt enable.
- 2: source-ID compare value.
- 3: core-event mask, one bit per core event.
- 4: command. It is write-only and reads 0.

Top module: `netStatusReg`

## Requirements
- R1: After the asynchronous active-low reset, these are all zero: the status register at address 0, the enable register at address 1, the compare value at address 2, the core mask at address 3, and `irq`.
- R2: A set flag stays set in the cycles that follow until something clears it: a write-1 clear, software reset, or its own extra clear source.
- R3: A write to address 0 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If a set event and a clear for the same flag arrive in the same cycle, the flag ends up set. Software reset is the exception: it beats every set event.
- R5: A write to address 4 with data bit 0 set is a software reset. It clears every status flag and leaves the enable, compare and mask registers unchanged.
- R6: Status bit 9 (receive complete) sets on `rxLocalDone`. It clears on `rxStart`, which marks a reception in progress.
- R7: Status bit 8 sets when `rxSrcValid` is high and `rxSrcId` equals the compare value at address 2.
- R8: Status bit 4 sets on `pktDone` when `pktOffset` is 0, 1 or 2, or when it is equal to or greater than PAGE_BYTES (default 256).
- R9: Status bit 3 sets when any bit of `coreEvent` is high and the same bit of the core mask at address 3 is 1.
- R10: `fbeNoResp` sets status bits 2 and 1 in the same cycle. `txErr` sets bit 1 alone.
- R11: A write to address 4 with data bit 1 set is a send command. It clears status bit 2 and no other bit.
- R12: `irq` is high exactly when some status bit is 1 and the same bit of the enable register at address 1 is 1.
- R13: Status bits 7, 6 and 5 set on `tokenRetry`, `ackNakFix` and `hubWdtTimeout` respectively. Status bit 0 and bits 15 to 10 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | ADDR_W | Register address for reads and writes |
| hostWrEn | input | 1 | Write strobe, sampled on the rising edge |
| hostWrData | input | DATA_W | Write data |
| hostRdData | output | DATA_W | Read data for `hostAddr`, combinational |
| rxStart | input | 1 | A reception for the local node has begun |
| rxLocalDone | input | 1 | A local packet arrived without error |
| rxSrcValid | input | 1 | `rxSrcId` is valid this cycle |
| rxSrcId | input | SRC_ID_W | Source ID of the received packet |
| tokenRetry | input | 1 | A token retry happened |
| ackNakFix | input | 1 | A corrupt ACK/NAK countermeasure was applied |
| hubWdtTimeout | input | 1 | The hub watchdog expired |
| pktDone | input | 1 | Packet finished, so `pktOffset` is valid |
| pktOffset | input | OFF_W | Page offset field of that packet |
| coreEvent | input | CORE_EV_N | Core event pulses |
| fbeNoResp | input | 1 | A free-buffer enquiry got no response |
| txErr | input | 1 | Transmit error |
| irq | output | 1 | Summary interrupt |

## Verification
Every flag changes at the rising edge that samples its event or its clearing write. Read data and `irq` are combinational from that flag state, so both are due in the same cycle, shortly after that edge. The bench drives all stimulus at the falling edge. It then returns the address to 0, clears the event inputs 2 ns after the rising edge, and samples 1 ns later. This way every check sees the state that exactly one edge produced. The expected status comes from a model updated once per edge. The model applies software reset first, then set events, then clears, and it uses the register values that stood before any write in that same cycle.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  // Register addresses.
  localparam int ADR_STATUS = 0;
  localparam int ADR_IEN    = 1;
  localparam int ADR_SRCID  = 2;
  localparam int ADR_CMASK  = 3;
  localparam int ADR_CMD    = 4;

  // Command bits at ADR_CMD.
  localparam int CMD_SOFTRST = 0;
  localparam int CMD_SEND    = 1;

  // Status bit positions.
  localparam int FL_RXDONE = 9;
  localparam int FL_SRCHIT = 8;
  localparam int FL_TKNRTY = 7;
  localparam int FL_ACKFIX = 6;
  localparam int FL_HUBWDT = 5;
  localparam int FL_OFFERR = 4;
  localparam int FL_CORE   = 3;
  localparam int FL_NORESP = 2;
  localparam int FL_TXERR  = 1;

  // Smallest valid page offset.
  localparam int MIN_OFFSET = 3;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_IEN,
    SEL_SRC,
    SEL_CMASK,
    SEL_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrIen;
    logic   wrSrc;
    logic   wrCmask;
    logic   softRst;
    logic   sendCmd;
    rdSel_e rdSel;
  } hostStrobe_t;

endpackage

// File: rtl/nsrCtrl.sv
module nsrCtrl
  import nsr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output hostStrobe_t       strobe
);

  logic hitStatus, hitIen, hitSrc, hitCmask, hitCmd;

  // One-hot address decode.
  always_comb begin
    hitStatus = (hostAddr == ADDR_W'(ADR_STATUS));
    hitIen    = (hostAddr == ADDR_W'(ADR_IEN));
    hitSrc    = (hostAddr == ADDR_W'(ADR_SRCID));
    hitCmask  = (hostAddr == ADDR_W'(ADR_CMASK));
    hitCmd    = (hostAddr == ADDR_W'(ADR_CMD));
  end

  // Qualify the decode with the write strobe and the command bits.
  always_comb begin
    strobe.wrStatus = hostWrEn & hitStatus;
    strobe.wrIen    = hostWrEn & hitIen;
    strobe.wrSrc    = hostWrEn & hitSrc;
    strobe.wrCmask  = hostWrEn & hitCmask;
    strobe.softRst  = hostWrEn & hitCmd & hostWrData[CMD_SOFTRST];
    strobe.sendCmd  = hostWrEn & hitCmd & hostWrData[CMD_SEND];

    if (hitStatus)     strobe.rdSel = SEL_STATUS;
    else if (hitIen)   strobe.rdSel = SEL_IEN;
    else if (hitSrc)   strobe.rdSel = SEL_SRC;
    else if (hitCmask) strobe.rdSel = SEL_CMASK;
    else               strobe.rdSel = SEL_ZERO;
  end

endmodule

// File: rtl/nsrDatapath.sv
module nsrDatapath
  import nsr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SRC_ID_W   = 8,
  parameter int OFF_W      = 10,
  parameter int PAGE_BYTES = 256,
  parameter int CORE_EV_N  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hostStrobe_t          strobe,
  input  logic [DATA_W-1:0]    hostWrData,
  input  logic                 rxStart,
  input  logic                 rxLocalDone,
  input  logic                 rxSrcValid,
  input  logic [SRC_ID_W-1:0]  rxSrcId,
  input  logic                 tokenRetry,
  input  logic                 ackNakFix,
  input  logic                 hubWdtTimeout,
  input  logic                 pktDone,
  input  logic [OFF_W-1:0]     pktOffset,
  input  logic [CORE_EV_N-1:0] coreEvent,
  input  logic                 fbeNoResp,
  input  logic                 txErr,
  output logic [DATA_W-1:0]    flagQ,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irq
);

  // Bits that hold a flag. All other bits read 0.
  localparam logic [DATA_W-1:0] LIVE_MASK =
      (DATA_W'(1) << FL_RXDONE) | (DATA_W'(1) << FL_SRCHIT) |
      (DATA_W'(1) << FL_TKNRTY) | (DATA_W'(1) << FL_ACKFIX) |
      (DATA_W'(1) << FL_HUBWDT) | (DATA_W'(1) << FL_OFFERR) |
      (DATA_W'(1) << FL_CORE)   | (DATA_W'(1) << FL_NORESP) |
      (DATA_W'(1) << FL_TXERR);
  localparam logic [OFF_W-1:0] OFF_LOW  = OFF_W'(MIN_OFFSET);
  localparam logic [OFF_W-1:0] OFF_HIGH = OFF_W'(PAGE_BYTES);

  logic [DATA_W-1:0]    ienQ;
  logic [SRC_ID_W-1:0]  srcQ;
  logic [CORE_EV_N-1:0] cmaskQ;
  logic [DATA_W-1:0]    setVec, clrVec, flagD;
  logic                 offBad, srcHit, coreHit;

  // Host-programmed configuration registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienQ   <= '0;
      srcQ   <= '0;
      cmaskQ <= '0;
    end else begin
      if (strobe.wrIen)   ienQ   <= hostWrData & LIVE_MASK;
      if (strobe.wrSrc)   srcQ   <= hostWrData[SRC_ID_W-1:0];
      if (strobe.wrCmask) cmaskQ <= hostWrData[CORE_EV_N-1:0];
    end
  end

  // Event qualification.
  always_comb begin
    offBad  = pktDone & ((pktOffset < OFF_LOW) | (pktOffset >= OFF_HIGH));
    srcHit  = rxSrcValid & (rxSrcId == srcQ);
    coreHit = |(coreEvent & cmaskQ);
  end

  always_comb begin
    setVec            = '0;
    setVec[FL_RXDONE] = rxLocalDone;
    setVec[FL_SRCHIT] = srcHit;
    setVec[FL_TKNRTY] = tokenRetry;
    setVec[FL_ACKFIX] = ackNakFix;
    setVec[FL_HUBWDT] = hubWdtTimeout;
    setVec[FL_OFFERR] = offBad;
    setVec[FL_CORE]   = coreHit;
    setVec[FL_NORESP] = fbeNoResp;
    setVec[FL_TXERR]  = fbeNoResp | txErr;
  end

  // Write-1 clears plus the per-flag extra clear sources.
  always_comb begin
    clrVec            = strobe.wrStatus ? hostWrData : '0;
    clrVec[FL_RXDONE] = clrVec[FL_RXDONE] | rxStart;
    clrVec[FL_NORESP] = clrVec[FL_NORESP] | strobe.sendCmd;
  end

  // Per-bit next state: software reset first, then set, then clear.
  for (genvar b = 0; b < DATA_W; b++) begin : g_flag
    if (LIVE_MASK[b]) begin : g_live
      assign flagD[b] = strobe.softRst ? 1'b0 :
                        setVec[b]      ? 1'b1 :
                        clrVec[b]      ? 1'b0 : flagQ[b];
    end else begin : g_rsvd
      assign flagD[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagD;
  end

  assign irq = |(flagQ & ienQ);

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STATUS: rdData = flagQ;
      SEL_IEN:    rdData = ienQ;
      SEL_SRC:    rdData = DATA_W'(srcQ);
      SEL_CMASK:  rdData = DATA_W'(cmaskQ);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/netStatusReg.sv
module netStatusReg
  import nsr_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int SRC_ID_W   = 8,
  parameter int OFF_W      = 10,
  parameter int PAGE_BYTES = 256,
  parameter int CORE_EV_N  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic                 hostWrEn,
  input  logic [DATA_W-1:0]    hostWrData,
  output logic [DATA_W-1:0]    hostRdData,
  input  logic                 rxStart,
  input  logic                 rxLocalDone,
  input  logic                 rxSrcValid,
  input  logic [SRC_ID_W-1:0]  rxSrcId,
  input  logic                 tokenRetry,
  input  logic                 ackNakFix,
  input  logic                 hubWdtTimeout,
  input  logic                 pktDone,
  input  logic [OFF_W-1:0]     pktOffset,
  input  logic [CORE_EV_N-1:0] coreEvent,
  input  logic                 fbeNoResp,
  input  logic                 txErr,
  output logic                 irq
);

  hostStrobe_t       strobe;
  logic [DATA_W-1:0] flagQ;

  nsrCtrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .strobe     (strobe)
  );

  nsrDatapath #(
    .DATA_W     (DATA_W),
    .SRC_ID_W   (SRC_ID_W),
    .OFF_W      (OFF_W),
    .PAGE_BYTES (PAGE_BYTES),
    .CORE_EV_N  (CORE_EV_N)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .hostWrData    (hostWrData),
    .rxStart       (rxStart),
    .rxLocalDone   (rxLocalDone),
    .rxSrcValid    (rxSrcValid),
    .rxSrcId       (rxSrcId),
    .tokenRetry    (tokenRetry),
    .ackNakFix     (ackNakFix),
    .hubWdtTimeout (hubWdtTimeout),
    .pktDone       (pktDone),
    .pktOffset     (pktOffset),
    .coreEvent     (coreEvent),
    .fbeNoResp     (fbeNoResp),
    .txErr         (txErr),
    .flagQ         (flagQ),
    .rdData        (hostRdData),
    .irq           (irq)
  );

endmodule

// File: rtl/nsrChecker.sv
module nsrChecker #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWrEn,
  input logic [DATA_W-1:0] hostWrData,
  input logic              hubWdtTimeout,
  input logic              ackNakFix,
  input logic              fbeNoResp,
  input logic              pktDone,
  input logic [OFF_W-1:0]  pktOffset,
  input logic [DATA_W-1:0] flagQ
);

  logic softWr, statWr;
  assign softWr = hostWrEn && (hostAddr == ADDR_W'(4)) && hostWrData[0];
  assign statWr = hostWrEn && (hostAddr == ADDR_W'(0));

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[6] && !(statWr && hostWrData[6]) && !softWr) |=> flagQ[6]);

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && hostWrData[5] && !hubWdtTimeout) |=> !flagQ[5]);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hubWdtTimeout && !softWr) |=> flagQ[5]);

  // R5
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> (flagQ == '0));

  // R8
  low_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && (pktOffset < OFF_W'(3)) && !softWr) |=> flagQ[4]);

  // R10
  noresp_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fbeNoResp && !softWr) |=> (flagQ[2] && flagQ[1]));

  // R13
  ackfix_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackNakFix && !softWr) |=> flagQ[6]);

endmodule

bind netStatusReg nsrChecker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OFF_W  (OFF_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .hostAddr      (hostAddr),
  .hostWrEn      (hostWrEn),
  .hostWrData    (hostWrData),
  .hubWdtTimeout (hubWdtTimeout),
  .ackNakFix     (ackNakFix),
  .fbeNoResp     (fbeNoResp),
  .pktDone       (pktDone),
  .pktOffset     (pktOffset),
  .flagQ         (flagQ)
);

// File: tb/sim_netStatusReg.sv
module sim_netStatusReg;

  localparam logic [15:0] LIVE = 16'h03FE;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  hostAddr;
  logic        hostWrEn;
  logic [15:0] hostWrData;
  logic [15:0] hostRdData;
  logic        rxStart, rxLocalDone, rxSrcValid;
  logic [7:0]  rxSrcId;
  logic        tokenRetry, ackNakFix, hubWdtTimeout, pktDone;
  logic [9:0]  pktOffset;
  logic [3:0]  coreEvent;
  logic        fbeNoResp, txErr, irq;

  int nRun  = 0;
  int nFail = 0;
  logic [15:0] expFlags, expIen;
  logic [7:0]  expSrc;
  logic [3:0]  expCm;

  always #10 clk = ~clk;

  netStatusReg u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .rxStart(rxStart),
    .rxLocalDone(rxLocalDone), .rxSrcValid(rxSrcValid), .rxSrcId(rxSrcId),
    .tokenRetry(tokenRetry), .ackNakFix(ackNakFix),
    .hubWdtTimeout(hubWdtTimeout), .pktDone(pktDone), .pktOffset(pktOffset),
    .coreEvent(coreEvent), .fbeNoResp(fbeNoResp), .txErr(txErr), .irq(irq)
  );

  // Expected status after one edge with the inputs now on the pins.
  function automatic logic [15:0] nextFlags(input logic [15:0] f);
    logic [15:0] setV = '0;
    logic [15:0] clrV = '0;
    if (hostWrEn && hostAddr == 3'd0) clrV = hostWrData;
    if (hostWrEn && hostAddr == 3'd4 && hostWrData[1]) clrV[2] = 1'b1;
    if (rxStart) clrV[9] = 1'b1;
    setV[9] = rxLocalDone;
    setV[8] = rxSrcValid && (rxSrcId == expSrc);
    setV[7] = tokenRetry;
    setV[6] = ackNakFix;
    setV[5] = hubWdtTimeout;
    setV[4] = pktDone && (pktOffset < 10'd3 || pktOffset >= 10'd256);
    setV[3] = |(coreEvent & expCm);
    setV[2] = fbeNoResp;
    setV[1] = fbeNoResp || txErr;
    if (hostWrEn && hostAddr == 3'd4 && hostWrData[0]) return 16'h0;
    return ((f & ~clrV) | setV) & LIVE;
  endfunction

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    hostAddr = 3'd0; hostWrEn = 1'b0; hostWrData = '0;
    rxStart = 0; rxLocalDone = 0; rxSrcValid = 0; rxSrcId = '0;
    tokenRetry = 0; ackNakFix = 0; hubWdtTimeout = 0; pktDone = 0;
    pktOffset = '0; coreEvent = '0; fbeNoResp = 0; txErr = 0;
  endtask

  // Called at a falling edge with the inputs already driven.
  task automatic tick(input string tag);
    logic [15:0] nf = nextFlags(expFlags);
    if (hostWrEn && hostAddr == 3'd1) expIen = hostWrData & LIVE;
    if (hostWrEn && hostAddr == 3'd2) expSrc = hostWrData[7:0];
    if (hostWrEn && hostAddr == 3'd3) expCm  = hostWrData[3:0];
    expFlags = nf;
    @(posedge clk);
    #2 idle();
    #1;
    check(tag, hostRdData, expFlags);
    check("R12 irq", {15'b0, irq}, {15'b0, |(expFlags & expIen)});
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
  endtask

  task automatic readReg(input logic [2:0] a, input logic [15:0] exp,
                         input string tag);
    hostAddr = a;
    #1 check(tag, hostRdData, exp);
    hostAddr = 3'd0;
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED1234);
    idle();
    rstN = 1'b0;
    expFlags = '0; expIen = '0; expSrc = '0; expCm = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(3'd0, 16'h0, "R1 status");
    readReg(3'd1, 16'h0, "R1 ien");
    readReg(3'd2, 16'h0, "R1 src");
    readReg(3'd3, 16'h0, "R1 cmask");
    check("R1 irq", {15'b0, irq}, 16'h0);

    // R13 simple event flags
    hubWdtTimeout = 1; tick("R13 hub");
    tokenRetry = 1;    tick("R13 token");
    ackNakFix = 1;     tick("R13 acknak");
    // R2 sticky across idle cycles
    tick("R2 hold"); tick("R2 hold");
    // R3 zero bits have no effect, one bits clear
    wr(3'd0, 16'h0000); tick("R3 zeros");
    wr(3'd0, 16'h0080); tick("R3 clear bit7");
    // R4 set beats same-cycle clear
    wr(3'd0, 16'h0020); hubWdtTimeout = 1; tick("R4 set wins");
    // R6 receive complete
    rxLocalDone = 1; tick("R6 set");
    rxStart = 1;     tick("R6 clear on start");
    rxStart = 1; rxLocalDone = 1; tick("R6 set beats start");
    // R7 source match
    wr(3'd2, 16'h005A); tick("R7 program");
    readReg(3'd2, 16'h005A, "R7 readback");
    rxSrcValid = 1; rxSrcId = 8'h5B; tick("R7 mismatch");
    rxSrcValid = 1; rxSrcId = 8'h5A; tick("R7 match");
    // R8 offset boundaries
    foreach (expIen[i]) if (i < 6) begin
      logic [9:0] offs [6] = '{10'd0, 10'd2, 10'd3, 10'd255, 10'd256, 10'd700};
      wr(3'd0, 16'h0010); tick("R8 clear");
      pktDone = 1; pktOffset = offs[i]; tick("R8 offset");
    end
    // R9 core mask gating
    coreEvent = 4'hF; tick("R9 mask zero");
    wr(3'd3, 16'h0001); tick("R9 program");
    coreEvent = 4'b0010; tick("R9 masked");
    coreEvent = 4'b0001; tick("R9 enabled");
    // R10 and R11
    wr(3'd0, 16'h0006); tick("R10 clear");
    txErr = 1; tick("R10 txerr only");
    fbeNoResp = 1; tick("R10 pair");
    wr(3'd4, 16'h0002); tick("R11 send clears bit2");
    // R12 enable mask
    wr(3'd1, 16'h0200); tick("R12 ien rx");
    wr(3'd1, 16'hFFFF); tick("R12 ien all");
    readReg(3'd1, 16'h03FE, "R12 ien readback");
    // R5 software reset keeps configuration
    wr(3'd4, 16'h0001); tick("R5 soft reset");
    readReg(3'd1, 16'h03FE, "R5 ien kept");
    readReg(3'd3, 16'h0001, "R5 cmask kept");
    readReg(3'd4, 16'h0000, "R13 cmd reads zero");

    // Constrained random mix
    for (int n = 0; n < 800; n++) begin
      logic [15:0] d = 16'($urandom);
      rxStart       = ($urandom_range(0, 7) == 0);
      rxLocalDone   = ($urandom_range(0, 5) == 0);
      rxSrcValid    = ($urandom_range(0, 3) == 0);
      rxSrcId       = ($urandom_range(0, 1) == 0) ? expSrc : 8'($urandom);
      tokenRetry    = ($urandom_range(0, 9) == 0);
      ackNakFix     = ($urandom_range(0, 9) == 0);
      hubWdtTimeout = ($urandom_range(0, 9) == 0);
      pktDone       = ($urandom_range(0, 4) == 0);
      pktOffset     = ($urandom_range(0, 1) == 0) ? 10'($urandom_range(0, 5))
                                                  : 10'($urandom_range(250, 262));
      coreEvent     = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      fbeNoResp     = ($urandom_range(0, 9) == 0);
      txErr         = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 2) == 0) begin
        hostWrEn = 1'b1;
        hostAddr = 3'($urandom_range(0, 5));
        if (hostAddr == 3'd4) begin
          d[0] = ($urandom_range(0, 15) == 0);
        end
        hostWrData = d;
      end
      tick("R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule